// File: doc/BRIEF.md
# Start/Done Controlled Accumulate Core

This block is a small arithmetic core driven by a four-signal control handshake. A controller raises a start request. The core answers with a one-cycle ready pulse in the cycle where it reads its operands. It then presents an accumulated result with its own valid strobe. Finally it signals completion with a one-cycle done pulse, in the same cycle that a return value appears.

Two plain operands carry no handshake of their own. The driver must hold them steady until the ready cycle has ended. A third operand acts as a read-modify-write accumulator. Its old value enters on a dedicated input port, and its new value leaves on a separate output port.

The core makes two results. The accumulator result is the sum of all three operands. The return value is the sum of the two plain operands. Both are taken modulo 2^W.

A controller that keeps start high across the done cycle chains transactions back to back. In that case the idle flag never rises between them.

Top module: `compute_handshake_core`

## Requirements
- R1: While reset is high, and in the first cycle after it, idle_o is 1 and ready_o, done_o, acc_vld_o, acc_o and ret_o are all 0.
- R2: When start_i is sampled high at a clock edge while idle_o is 1, a transaction begins: in the next cycle idle_o is 0 and ready_o is 1. With start_i low, idle_o stays 1.
- R3: ready_o is high for exactly one cycle, the cycle after the starting edge. opa_i, opb_i and acc_i are captured at the clock edge that ends that cycle. Changes after that edge have no effect on the results.
- R4: In the cycle after ready_o, acc_vld_o is high for exactly one cycle. In that cycle acc_o equals (opa_i + opb_i + acc_i) mod 2^W. acc_o holds this value until the next acc_vld_o pulse.
- R5: In the cycle after acc_vld_o, done_o is high for exactly one cycle. In that cycle ret_o equals (opa_i + opb_i) mod 2^W. ret_o holds this value until the next done_o pulse.
- R6: idle_o is 0 from the ready cycle through the done cycle. It returns to 1 in the cycle after done_o when start_i is low at that edge.
- R7: If start_i is high at the edge that ends the done cycle, a new transaction begins at once: ready_o is 1 in the next cycle and idle_o stays 0.
- R8: start_i is ignored during the ready and valid cycles. Holding it high there starts no extra transaction: after done_o with start_i low, idle_o rises and ready_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Transaction request |
| ready_o | output | 1 | One-cycle pulse: operands are being read |
| done_o | output | 1 | One-cycle pulse: transaction complete, ret_o valid |
| idle_o | output | 1 | High while waiting for a start |
| opa_i | input | W | First plain operand |
| opb_i | input | W | Second plain operand |
| acc_i | input | W | Old accumulator value |
| acc_o | output | W | New accumulator value |
| acc_vld_o | output | 1 | One-cycle strobe: acc_o valid |
| ret_o | output | W | Return value, opa + opb |

## Verification
The bench builds the core with W = 8. This keeps operands small enough that all-ones inputs push both sums past 2^W, so the modulo wrap of acc_o and ret_o is exercised directly.

Between the ready edge and the done cycle, the operands are deliberately scrambled. This shows that the capture point is the only one that matters. Back-to-back chaining and start held high through the busy cycles both run at this width.

// File: rtl/compute_handshake_core.sv
module compute_handshake_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  output logic         ready_o,
  output logic         done_o,
  output logic         idle_o,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] acc_i,
  output logic [W-1:0] acc_o,
  output logic         acc_vld_o,
  output logic [W-1:0] ret_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_ACC, ST_FIN} st_t;

  st_t         st, st_nx;
  logic [W-1:0] pair_q, acc_q, ret_q;
  logic [W-1:0] pair_w;
  logic         launch;

  assign pair_w = opa_i + opb_i;
  assign launch = start_i && (st == ST_IDLE || st == ST_FIN);

  always_comb begin
    case (st)
      ST_IDLE: st_nx = launch ? ST_READ : ST_IDLE;
      ST_READ: st_nx = ST_ACC;
      ST_ACC:  st_nx = ST_FIN;
      ST_FIN:  st_nx = launch ? ST_READ : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pair_q <= '0;
      acc_q  <= '0;
      ret_q  <= '0;
    end else begin
      st <= st_nx;
      if (st == ST_READ) begin
        pair_q <= pair_w;
        acc_q  <= pair_w + acc_i;
      end
      if (st == ST_ACC) ret_q <= pair_q;
    end
  end

  assign ready_o   = (st == ST_READ);
  assign acc_vld_o = (st == ST_ACC);
  assign done_o    = (st == ST_FIN);
  assign idle_o    = (st == ST_IDLE);
  assign acc_o     = acc_q;
  assign ret_o     = ret_q;

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    idle_o && !start_i |=> idle_o);
  p_start_ready_r2: assert property (@(posedge clk) disable iff (rst)
    idle_o && start_i |=> ready_o && !idle_o);
  p_ready_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> !ready_o);
  p_vld_after_ready_r4: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> acc_vld_o);
  p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !acc_vld_o |-> $stable(acc_o));
  p_done_after_vld_r5: assert property (@(posedge clk) disable iff (rst)
    acc_vld_o |=> done_o && !acc_vld_o);
  p_ret_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(ret_o));
  p_busy_not_idle_r6: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> !ready_o && !acc_vld_o && !done_o);
  p_chain_r7: assert property (@(posedge clk) disable iff (rst)
    done_o && start_i |=> ready_o && !idle_o);
  p_one_phase_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({idle_o, ready_o, acc_vld_o, done_o}) == 1);

endmodule

// File: tb/compute_handshake_core_test.sv
module compute_handshake_core_test;
  localparam int W = 8;

  logic         clk = 0;
  logic         rst = 1;
  logic         start_i = 0;
  logic [W-1:0] opa_i = '0, opb_i = '0, acc_i = '0;
  logic         ready_o, done_o, idle_o, acc_vld_o;
  logic [W-1:0] acc_o, ret_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct packed { logic [W-1:0] acc; logic [W-1:0] ret; } exp_t;
  exp_t exp_q[$];
  logic [W-1:0] last_acc = '0, last_ret = '0;

  compute_handshake_core #(.W(W)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .ready_o(ready_o),
    .done_o(done_o), .idle_o(idle_o), .opa_i(opa_i), .opb_i(opb_i),
    .acc_i(acc_i), .acc_o(acc_o), .acc_vld_o(acc_vld_o), .ret_o(ret_o));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (acc_vld_o) begin
        if (exp_q.size() == 0) check(0, "R4 unexpected acc_vld_o", 1, 0);
        else check(acc_o == exp_q[0].acc, "R4 acc_o", acc_o, exp_q[0].acc);
        last_acc = acc_o;
      end
      if (done_o) begin
        if (exp_q.size() == 0) check(0, "R5 unexpected done_o", 1, 0);
        else begin
          check(ret_o == exp_q[0].ret, "R5 ret_o", ret_o, exp_q[0].ret);
          last_ret = ret_o;
          void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic txn(input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic [W-1:0] c, input bit hold_busy);
    exp_t e;
    e.ret = a + b;
    e.acc = a + b + c;
    exp_q.push_back(e);
    start_i = 1; opa_i = a; opb_i = b; acc_i = c;
    @(negedge clk);
    check(ready_o == 1, "R2/R3 ready_o after start", ready_o, 1);
    check(idle_o == 0, "R6 idle_o in ready cycle", idle_o, 0);
    start_i = hold_busy;
    @(negedge clk);
    check(acc_vld_o == 1 && ready_o == 0, "R3/R4 ready pulse then acc_vld_o", acc_vld_o, 1);
    opa_i = ~a; opb_i = a ^ 8'h5a; acc_i = c + 8'd77;
    @(negedge clk);
    check(done_o == 1 && idle_o == 0, "R5/R6 done_o with idle_o low", done_o, 1);
    start_i = 0;
  endtask

  task automatic expect_idle_after();
    @(negedge clk);
    check(idle_o == 1, "R6 idle_o after done", idle_o, 1);
    check(ready_o == 0 && done_o == 0, "R8 no extra transaction", ready_o, 0);
    check(acc_o == last_acc, "R4 acc_o holds", acc_o, last_acc);
    check(ret_o == last_ret, "R5 ret_o holds", ret_o, last_ret);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(idle_o == 1 && ready_o == 0 && done_o == 0 && acc_vld_o == 0,
          "R1 control in reset", idle_o, 1);
    check(acc_o == 0 && ret_o == 0, "R1 data in reset", acc_o, 0);
    rst = 0;
    @(negedge clk);
    check(idle_o == 1 && acc_o == 0 && ret_o == 0, "R1 after release", idle_o, 1);
    @(negedge clk);
    check(idle_o == 1 && ready_o == 0, "R2 no start stays idle", idle_o, 1);

    txn(8'd3, 8'd4, 8'd10, 0);
    expect_idle_after();
    txn(8'd255, 8'd255, 8'd255, 0);
    expect_idle_after();
    txn(8'd128, 8'd128, 8'd1, 1);
    expect_idle_after();
    txn(8'd17, 8'd40, 8'd200, 0);
    txn(8'd99, 8'd1, 8'd0, 0);
    txn(8'd0, 8'd0, 8'd0, 0);
    expect_idle_after();
    repeat (3) @(negedge clk);
    check(idle_o == 1 && exp_q.size() == 0, "R7 chained queue drained", exp_q.size(), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule